// File: doc/BRIEF.md
# Flash Completion Poller

This block sits on the host side of a parallel NOR-style flash and decides when a program or erase operation inside the device has finished. It does not watch a ready pin. Instead it issues status reads in pairs and compares the toggle bit (data bit 6) between the two bytes of each pair. A toggle bit that does not change means the operation is over. A toggle bit that keeps changing means the device is still busy.

While the toggle bit is changing, the block also watches the timing-limit bit (data bit 5). If that bit is set, it makes one more pair of reads before it calls the operation failed. A failure raises a one-cycle request for the external command sequencer to reset the device. A programmable watchdog ends polling with a time-out result after a set number of toggling pairs.

In a second mode the block guards the addition of one more sector erase command:
- It reads the erase-timer bit (data bit 3) before the command is written.
- It hands the bus to the external sequencer through a request/acknowledge pair.
- It reads the erase-timer bit again after the command, so software learns whether the command may have been rejected.

Every read drives chip enable, output enable and the address. Output enable is held low for a parameterised number of clocks, and both enables return high between reads.

Top module: `flash_toggle_poller`

## Requirements
- R1: After reset, `flash_ce_n` and `flash_oe_n` are 1, `busy` and `done` are 0, and `result` is 0 (none).
- R2: Each read drives `flash_ce_n` and `flash_oe_n` low together for exactly OE_CYCLES clocks. The data bus is sampled on the last of those clocks. Both enables then stay high for at least one clock before the next read. `flash_addr` holds the address captured at start for the whole operation.
- R3: Poll mode (`poll_start`) reads a pair of status bytes and compares their bit 6. If the two bits are equal, one further read is taken. That byte appears on `arr_data`, and the operation ends with `result` = 1 (ok).
- R4: If bit 6 differs within a pair and bit 5 of the second byte is 0, another pair is read.
- R5: If bit 6 differs and bit 5 of the second byte is 1, two more reads are taken. If their bit 6 values are equal, the array read follows and `result` = 1. If they differ, `result` = 2 (fail) with no array read.
- R6: `rst_seq_req` pulses for one cycle, together with `done`, exactly when `result` = 2.
- R7: After `max_pairs` toggling pairs with bit 5 clear, polling ends with `result` = 3 (time-out) and no array read. A `max_pairs` of 0 acts as 1.
- R8: Window mode (`win_start`) first reads one status byte. If bit 3 is 1, the operation ends with `result` = 4 (window closed) and `win_cmd_req` never rises.
- R9: If that first bit 3 is 0, `win_cmd_req` stays high with no read until `win_cmd_ack`. A second read then follows. Bit 3 = 1 on this read gives `result` = 5 (possibly rejected); bit 3 = 0 gives `result` = 1.
- R10: `done` is a one-cycle pulse with a non-zero `result`. `busy` is high from the cycle after a start until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| poll_start | input | 1 | Begin completion polling |
| win_start | input | 1 | Begin erase-window guard around one added command |
| addr_i | input | AW | Bank/sector address to read from |
| max_pairs | input | PW | Watchdog limit in toggling pairs |
| flash_dq | input | 8 | Flash data bus |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_addr | output | AW | Flash address |
| win_cmd_req | output | 1 | External sequencer may write the erase command |
| win_cmd_ack | input | 1 | Command written |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 none, 1 ok, 2 fail, 3 time-out, 4 window closed, 5 possibly rejected |
| arr_data | output | 8 | Byte from the array read after completion |
| rst_seq_req | output | 1 | Request to issue the reset command sequence |

## Verification
The bound assertions check the bus protocol on every cycle:
- output enable never goes low without chip enable;
- each low phase lasts exactly OE_CYCLES clocks, with a high gap after it;
- the address stays fixed during a read;
- no read happens while the command request is up;
- `done`, `result` and `rst_seq_req` stay consistent with one another.

Only the bench scenarios can show the decision paths. A scripted status sequence checks that a stable toggle bit leads to the array read, that a toggling pair is followed by another pair, and that the timing-limit recheck ends in success or failure. It also checks that the watchdog limit (including zero) is honoured and that the erase-timer bit before and after the command yields the three window outcomes. Each of these is checked by the number of reads issued and the result code.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    localparam int TOG_BIT   = 6;
    localparam int LIMIT_BIT = 5;
    localparam int WIN_BIT   = 3;

    typedef enum logic [2:0] {
        RES_NONE       = 3'd0,
        RES_OK         = 3'd1,
        RES_FAIL       = 3'd2,
        RES_TIMEOUT    = 3'd3,
        RES_WIN_CLOSED = 3'd4,
        RES_REJECT     = 3'd5
    } poll_res_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POLL_A,
        ST_POLL_B,
        ST_RECHK_A,
        ST_RECHK_B,
        ST_ARRAY,
        ST_WIN_PRE,
        ST_WIN_CMD,
        ST_WIN_POST
    } poll_st_e;

    typedef enum logic [1:0] {
        RP_IDLE,
        RP_ACT,
        RP_GAP
    } rd_phase_e;

endpackage

// File: rtl/flash_read_port.sv
module flash_read_port
    import flash_poll_pkg::*;
#(
    parameter int AW        = 20,
    parameter int OE_CYCLES = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] addr_i,
    output logic          ready,
    output logic          valid,
    output logic [7:0]    data_o,
    input  logic [7:0]    dq_i,
    output logic          ce_n,
    output logic          oe_n,
    output logic [AW-1:0] addr_o
);

    localparam int CW = (OE_CYCLES > 1) ? $clog2(OE_CYCLES) : 1;

    typedef struct packed {
        rd_phase_e     phase;
        logic [CW-1:0] cnt;
        logic [7:0]    data;
        logic          valid;
        logic [AW-1:0] addr;
    } rp_state_t;

    rp_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        case (s_q.phase)
            RP_IDLE: begin
                if (req) begin
                    s_d.phase = RP_ACT;
                    s_d.cnt   = CW'(OE_CYCLES - 1);
                    s_d.addr  = addr_i;
                end
            end
            RP_ACT: begin
                if (s_q.cnt == '0) begin
                    s_d.data  = dq_i;
                    s_d.valid = 1'b1;
                    s_d.phase = RP_GAP;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.phase = RP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: RP_IDLE, cnt: '0, data: '0, valid: 1'b0, addr: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ready  = (s_q.phase == RP_IDLE);
    assign valid  = s_q.valid;
    assign data_o = s_q.data;
    assign ce_n   = (s_q.phase != RP_ACT);
    assign oe_n   = (s_q.phase != RP_ACT);
    assign addr_o = s_q.addr;

endmodule

// File: rtl/poll_pair_count.sv
module poll_pair_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         hit
);

    logic [W-1:0] cnt_d, cnt_q;
    logic [W:0]   cnt_next;

    assign cnt_next = {1'b0, cnt_q} + (W+1)'(1);
    assign hit      = (cnt_next >= {1'b0, limit});

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_next[W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller
    import flash_poll_pkg::*;
#(
    parameter int AW        = 20,
    parameter int OE_CYCLES = 3,
    parameter int PW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          poll_start,
    input  logic          win_start,
    input  logic [AW-1:0] addr_i,
    input  logic [PW-1:0] max_pairs,
    input  logic [7:0]    flash_dq,
    output logic          flash_ce_n,
    output logic          flash_oe_n,
    output logic [AW-1:0] flash_addr,
    output logic          win_cmd_req,
    input  logic          win_cmd_ack,
    output logic          busy,
    output logic          done,
    output logic [2:0]    result,
    output logic [7:0]    arr_data,
    output logic          rst_seq_req
);

    typedef struct packed {
        poll_st_e      st;
        logic          issued;
        logic          tog;
        logic [AW-1:0] addr;
        poll_res_e     res;
        logic          done;
        logic          rst_req;
        logic [7:0]    arr;
    } ctl_state_t;

    ctl_state_t c_d, c_q;

    logic       rd_req, rd_ready, rd_valid;
    logic [7:0] rd_data;
    logic       cnt_clr, cnt_inc, cnt_hit;
    logic       is_read;

    flash_read_port #(.AW(AW), .OE_CYCLES(OE_CYCLES)) u_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (rd_req),
        .addr_i (c_q.addr),
        .ready  (rd_ready),
        .valid  (rd_valid),
        .data_o (rd_data),
        .dq_i   (flash_dq),
        .ce_n   (flash_ce_n),
        .oe_n   (flash_oe_n),
        .addr_o (flash_addr)
    );

    poll_pair_count #(.W(PW)) u_wdog (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .limit (max_pairs),
        .hit   (cnt_hit)
    );

    always_comb begin
        case (c_q.st)
            ST_POLL_A, ST_POLL_B, ST_RECHK_A, ST_RECHK_B,
            ST_ARRAY, ST_WIN_PRE, ST_WIN_POST: is_read = 1'b1;
            default:                           is_read = 1'b0;
        endcase
    end

    always_comb begin
        c_d         = c_q;
        c_d.done    = 1'b0;
        c_d.rst_req = 1'b0;
        rd_req      = 1'b0;
        cnt_clr     = 1'b0;
        cnt_inc     = 1'b0;

        if (is_read && !c_q.issued && rd_ready) begin
            rd_req     = 1'b1;
            c_d.issued = 1'b1;
        end
        if (rd_valid) begin
            c_d.issued = 1'b0;
        end

        case (c_q.st)
            ST_IDLE: begin
                if (poll_start) begin
                    c_d.st   = ST_POLL_A;
                    c_d.addr = addr_i;
                    c_d.res  = RES_NONE;
                    cnt_clr  = 1'b1;
                end else if (win_start) begin
                    c_d.st   = ST_WIN_PRE;
                    c_d.addr = addr_i;
                    c_d.res  = RES_NONE;
                end
            end
            ST_POLL_A, ST_RECHK_A: begin
                if (rd_valid) begin
                    c_d.tog = rd_data[TOG_BIT];
                    c_d.st  = (c_q.st == ST_POLL_A) ? ST_POLL_B : ST_RECHK_B;
                end
            end
            ST_POLL_B: begin
                if (rd_valid) begin
                    if (rd_data[TOG_BIT] == c_q.tog) begin
                        c_d.st = ST_ARRAY;
                    end else if (rd_data[LIMIT_BIT]) begin
                        c_d.st = ST_RECHK_A;
                    end else begin
                        cnt_inc = 1'b1;
                        if (cnt_hit) begin
                            c_d.st   = ST_IDLE;
                            c_d.done = 1'b1;
                            c_d.res  = RES_TIMEOUT;
                        end else begin
                            c_d.st = ST_POLL_A;
                        end
                    end
                end
            end
            ST_RECHK_B: begin
                if (rd_valid) begin
                    if (rd_data[TOG_BIT] == c_q.tog) begin
                        c_d.st = ST_ARRAY;
                    end else begin
                        c_d.st      = ST_IDLE;
                        c_d.done    = 1'b1;
                        c_d.res     = RES_FAIL;
                        c_d.rst_req = 1'b1;
                    end
                end
            end
            ST_ARRAY: begin
                if (rd_valid) begin
                    c_d.arr  = rd_data;
                    c_d.st   = ST_IDLE;
                    c_d.done = 1'b1;
                    c_d.res  = RES_OK;
                end
            end
            ST_WIN_PRE: begin
                if (rd_valid) begin
                    if (rd_data[WIN_BIT]) begin
                        c_d.st   = ST_IDLE;
                        c_d.done = 1'b1;
                        c_d.res  = RES_WIN_CLOSED;
                    end else begin
                        c_d.st = ST_WIN_CMD;
                    end
                end
            end
            ST_WIN_CMD: begin
                if (win_cmd_ack) begin
                    c_d.st = ST_WIN_POST;
                end
            end
            ST_WIN_POST: begin
                if (rd_valid) begin
                    c_d.st   = ST_IDLE;
                    c_d.done = 1'b1;
                    c_d.res  = rd_data[WIN_BIT] ? RES_REJECT : RES_OK;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, issued: 1'b0, tog: 1'b0, addr: '0,
                     res: RES_NONE, done: 1'b0, rst_req: 1'b0, arr: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign busy        = (c_q.st != ST_IDLE);
    assign done        = c_q.done;
    assign result      = c_q.res;
    assign arr_data    = c_q.arr;
    assign rst_seq_req = c_q.rst_req;
    assign win_cmd_req = (c_q.st == ST_WIN_CMD);

endmodule

// File: rtl/flash_toggle_poller_chk.sv
module flash_toggle_poller_chk #(
    parameter int AW        = 20,
    parameter int OE_CYCLES = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flash_ce_n,
    input logic          flash_oe_n,
    input logic [AW-1:0] flash_addr,
    input logic          busy,
    input logic          done,
    input logic [2:0]    result,
    input logic          rst_seq_req,
    input logic          win_cmd_req
);

    logic [15:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!flash_oe_n) begin
            low_cnt <= (low_cnt == 16'hFFFF) ? low_cnt : low_cnt + 16'd1;
        end else begin
            low_cnt <= '0;
        end
    end

    assert_ce_with_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_oe_n |-> !flash_ce_n);

    assert_oe_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_oe_n) |=> (flash_oe_n && flash_ce_n));

    assert_oe_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_oe_n) |-> (low_cnt == 16'(OE_CYCLES)));

    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_oe_n && $past(!flash_oe_n)) |-> $stable(flash_addr));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && result != 3'd0));

    assert_rst_on_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_seq_req |-> (done && result == 3'd2));

    assert_no_read_in_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        win_cmd_req |-> flash_oe_n);

endmodule

bind flash_toggle_poller flash_toggle_poller_chk #(.AW(AW), .OE_CYCLES(OE_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flash_ce_n  (flash_ce_n),
    .flash_oe_n  (flash_oe_n),
    .flash_addr  (flash_addr),
    .busy        (busy),
    .done        (done),
    .result      (result),
    .rst_seq_req (rst_seq_req),
    .win_cmd_req (win_cmd_req)
);

// File: tb/flash_toggle_poller_bench.sv
module flash_toggle_poller_bench;

    localparam int AW = 20;
    localparam int OE = 3;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          poll_start = 1'b0;
    logic          win_start = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [PW-1:0] max_pairs = '0;
    logic [7:0]    flash_dq;
    logic          flash_ce_n, flash_oe_n;
    logic [AW-1:0] flash_addr;
    logic          win_cmd_req;
    logic          win_cmd_ack = 1'b0;
    logic          busy, done;
    logic [2:0]    result;
    logic [7:0]    arr_data;
    logic          rst_seq_req;

    int errors = 0;
    int checks = 0;

    // flash status model
    logic [7:0] seq [16];
    int rd_idx = 0;
    int low_len = 0;
    int len_err = 0;
    int addr_err = 0;
    int cmd_seen = 0;
    int done_seen = 0;
    int got_res = 0;
    int got_data = 0;
    int got_rst = 0;
    logic [AW-1:0] exp_addr = '0;

    always #10 clk = ~clk;

    assign flash_dq = (rd_idx < 16) ? seq[rd_idx] : 8'hFF;

    flash_toggle_poller #(.AW(AW), .OE_CYCLES(OE), .PW(PW)) u_flash_toggle_poller (
        .clk (clk), .rst_n (rst_n), .poll_start (poll_start), .win_start (win_start),
        .addr_i (addr_i), .max_pairs (max_pairs), .flash_dq (flash_dq),
        .flash_ce_n (flash_ce_n), .flash_oe_n (flash_oe_n), .flash_addr (flash_addr),
        .win_cmd_req (win_cmd_req), .win_cmd_ack (win_cmd_ack), .busy (busy),
        .done (done), .result (result), .arr_data (arr_data), .rst_seq_req (rst_seq_req)
    );

    always @(negedge clk) begin
        if (!flash_oe_n) begin
            low_len = low_len + 1;
            if (flash_addr !== exp_addr) addr_err = addr_err + 1;
        end else if (low_len != 0) begin
            if (low_len != OE) len_err = len_err + 1;
            rd_idx  = rd_idx + 1;
            low_len = 0;
        end
        if (win_cmd_req) cmd_seen = cmd_seen + 1;
        win_cmd_ack <= win_cmd_req;
        if (done) begin
            done_seen = 1;
            got_res   = int'(result);
            got_data  = int'(arr_data);
            got_rst   = int'(rst_seq_req);
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_op(input bit win_mode, input int limit, input logic [AW-1:0] a);
        @(negedge clk);
        rd_idx = 0; low_len = 0; len_err = 0; addr_err = 0;
        cmd_seen = 0; done_seen = 0; got_res = 0; got_data = 0; got_rst = 0;
        exp_addr  = a;
        addr_i    = a;
        max_pairs = PW'(limit);
        if (win_mode) win_start = 1'b1; else poll_start = 1'b1;
        @(negedge clk);
        win_start = 1'b0; poll_start = 1'b0;
        chk("R10", "busy after start", int'(busy), 1);
        for (int i = 0; i < 2000 && done_seen == 0; i++) @(negedge clk);
        chk("R2", "oe low length errors", len_err, 0);
        chk("R2", "address errors", addr_err, 0);
    endtask

    task automatic t_reset;
        chk("R1", "ce_n", int'(flash_ce_n), 1);
        chk("R1", "oe_n", int'(flash_oe_n), 1);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "result", int'(result), 0);
    endtask

    task automatic t_stable_first;
        seq[0] = 8'h44; seq[1] = 8'h44; seq[2] = 8'hA5;
        run_op(1'b0, 8, 20'h1_2345);
        chk("R3", "result", got_res, 1);
        chk("R3", "reads", rd_idx, 3);
        chk("R3", "array data", got_data, 8'hA5);
        chk("R6", "no reset request", got_rst, 0);
    endtask

    task automatic t_two_pairs;
        seq[0] = 8'h40; seq[1] = 8'h00; seq[2] = 8'h40; seq[3] = 8'h00;
        seq[4] = 8'h44; seq[5] = 8'h44; seq[6] = 8'h3C;
        run_op(1'b0, 8, 20'h0_0F00);
        chk("R4", "result", got_res, 1);
        chk("R4", "reads", rd_idx, 7);
        chk("R4", "array data", got_data, 8'h3C);
    endtask

    task automatic t_recheck_ok;
        seq[0] = 8'h40; seq[1] = 8'h20; seq[2] = 8'h24; seq[3] = 8'h24; seq[4] = 8'h5A;
        run_op(1'b0, 8, 20'h8_0001);
        chk("R5", "recheck ok result", got_res, 1);
        chk("R5", "recheck ok reads", rd_idx, 5);
        chk("R5", "recheck ok data", got_data, 8'h5A);
    endtask

    task automatic t_recheck_fail;
        seq[0] = 8'h40; seq[1] = 8'h20; seq[2] = 8'h60; seq[3] = 8'h20; seq[4] = 8'h77;
        run_op(1'b0, 8, 20'h8_0002);
        chk("R5", "recheck fail result", got_res, 2);
        chk("R5", "recheck fail reads", rd_idx, 4);
        chk("R6", "reset request with fail", got_rst, 1);
    endtask

    task automatic t_timeout(input int limit, input int exp_reads);
        for (int i = 0; i < 16; i++) seq[i] = (i % 2 == 0) ? 8'h40 : 8'h00;
        run_op(1'b0, limit, 20'h0_0010);
        chk("R7", "time-out result", got_res, 3);
        chk("R7", "time-out reads", rd_idx, exp_reads);
        chk("R6", "no reset request on time-out", got_rst, 0);
    endtask

    task automatic t_win(input logic [7:0] pre, input logic [7:0] post,
                         input int exp_res, input int exp_reads, input int exp_cmd);
        seq[0] = pre; seq[1] = post;
        run_op(1'b1, 8, 20'h4_4444);
        chk(exp_cmd != 0 ? "R9" : "R8", "window result", got_res, exp_res);
        chk(exp_cmd != 0 ? "R9" : "R8", "window reads", rd_idx, exp_reads);
        chk(exp_cmd != 0 ? "R9" : "R8", "command request seen", int'(cmd_seen != 0), exp_cmd);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) seq[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        t_stable_first;
        t_two_pairs;
        t_recheck_ok;
        t_recheck_fail;
        t_timeout(3, 6);
        t_timeout(0, 2);
        t_win(8'h00, 8'h00, 1, 2, 1);
        t_win(8'h00, 8'h08, 5, 2, 1);
        t_win(8'h08, 8'h00, 4, 1, 0);
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule